// File: doc/BRIEF.md
# Iterative Loop Adder

This block adds two unsigned words without a carry chain. Each clock it replaces its pair of working words with two new ones. The first is the bitwise exclusive-or of the pair, a sum that ignores carries. The second is the bitwise AND of the pair shifted up one place, which holds the carries still to be added. It stops as soon as the carry word is all zeros, and the sum word is then the answer.

The time to finish depends on the operands. This makes visible the contrast with an adder that produces its result in a single cycle.

A caller raises `start_i` for one cycle with both operands while `busy_o` is low. The block then runs on its own. It raises `done_o` for exactly one cycle, and in that cycle `sum_o` holds the result and `iters_o` holds the number of passes it used. Requests made while it runs are dropped.

Top module: `loop_adder`

## Requirements
- R1: After reset, `busy_o` and `done_o` are both low.
- R2: In the cycle `done_o` is high, `sum_o` equals (`a_i` + `b_i`) modulo 2^WIDTH for the accepted operands. A carry leaving the top bit is dropped.
- R3: Each pass sets the sum word to the exclusive-or of the two working words and the carry word to their AND shifted left by one. Adding 2 and 6 therefore gives sum 8 after 3 passes: the first pass gives sum 4 and carry 4, the second gives sum 0 and carry 8, and the third clears the carry.
- R4: When `b_i` is zero at acceptance, `sum_o` equals `a_i` and `iters_o` is 0.
- R5: `done_o` rises exactly `iters_o`+1 rising clock edges after the edge that accepted the request.
- R6: `done_o` is high for one cycle per request. `busy_o` is high from the accepting edge through the cycle in which `done_o` is high, and it is low in the following cycle.
- R7: A `start_i` while `busy_o` is high is ignored. The running result, its pass count and its timing are unchanged, and no extra `done_o` pulse follows.
- R8: The worst case, all ones plus one, yields 0 after WIDTH passes.
- R9: `iters_o` never exceeds WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only while idle |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, used as the initial carry word |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle result strobe |
| sum_o | output | WIDTH | Result, valid while done_o is high |
| iters_o | output | $clog2(WIDTH+1) | Passes used, valid while done_o is high |

## Verification
For a request whose reference pass count is n, the result, the pass count and `done_o` are all due after edge n+1, counted from the accepting edge. `busy_o` is due to fall one edge after that.

The bench counts falling edges after the accepting edge and takes all samples there. It requires the first high `done_o` at exactly count n+1, with the matching sum and count. It then requires `done_o` and `busy_o` to be low at the next falling edge.

Ignored requests are injected mid-run, and the bench confirms that the original answer still arrives on schedule.

// File: rtl/loop_add_pkg.sv
package loop_add_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } la_state_e;
endpackage

// File: rtl/la_step.sv
module la_step #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] car_q,
  output logic         car_zero
);
  function automatic logic [W-1:0] part_sum(input logic [W-1:0] u, input logic [W-1:0] v);
    return u ^ v;
  endfunction

  function automatic logic [W-1:0] part_carry(input logic [W-1:0] u, input logic [W-1:0] v);
    return (u & v) << 1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      car_q <= '0;
    end else if (load) begin
      sum_q <= op_a;
      car_q <= op_b;
    end else if (adv) begin
      sum_q <= part_sum(sum_q, car_q);
      car_q <= part_carry(sum_q, car_q);
    end
  end

  assign car_zero = (car_q == '0);

  logic [W-1:0] pair_total;
  assign pair_total = sum_q + car_q;

  p_total_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (pair_total == $past(pair_total)));

  p_carry_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (car_q[0] == 1'b0));
endmodule

// File: rtl/la_count.sv
module la_count #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] count_q
);
  localparam logic [CW-1:0] CMAX = CW'(W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count_q <= '0;
    else if (clear)                   count_q <= '0;
    else if (inc && count_q != CMAX)  count_q <= count_q + 1'b1;
  end

  p_count_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CMAX);
endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
  import loop_add_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic car_zero,
  output logic busy,
  output logic load,
  output logic adv,
  output logic done
);
  la_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    adv  = 1'b0;
    done = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        load = 1'b1;
        st_d = ST_RUN;
      end
      ST_RUN: if (car_zero) begin
        done = 1'b1;
        st_d = ST_IDLE;
      end else begin
        adv = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == ST_RUN);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);
endmodule

// File: rtl/loop_adder.sv
module loop_adder #(
  parameter int WIDTH = 32,
  localparam int CW   = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] sum_o,
  output logic [CW-1:0]    iters_o
);
  logic load_w, adv_w, car_zero_w;
  logic [WIDTH-1:0] car_w;

  la_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .car_zero (car_zero_w),
    .busy     (busy_o),
    .load     (load_w),
    .adv      (adv_w),
    .done     (done_o)
  );

  la_step #(.W(WIDTH)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .adv      (adv_w),
    .op_a     (a_i),
    .op_b     (b_i),
    .sum_q    (sum_o),
    .car_q    (car_w),
    .car_zero (car_zero_w)
  );

  la_count #(.W(WIDTH), .CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load_w),
    .inc     (adv_w),
    .count_q (iters_o)
  );

  p_zero_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && b_i == '0) |=> (done_o && iters_o == '0));

  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: tb/loop_adder_test.sv
module loop_adder_test;
  localparam int W  = 32;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic busy_o, done_o;
  logic [W-1:0] sum_o;
  logic [CW-1:0] iters_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  loop_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o), .iters_o(iters_o)
  );

  // Pass count: repeat the carry-free sum / carry split until no carry is left.
  function automatic int ref_passes(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W-1:0] s = p;
    logic [W-1:0] c = q;
    logic [W-1:0] nxt;
    for (int k = 0; k <= W; k++) begin
      if (c == '0) return k;
      nxt = (s & c) << 1;
      s = s ^ c;
      c = nxt;
    end
    return W + 1;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request; optionally poke a second start while busy.
  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke, input string req);
    int exp_n = ref_passes(a, b);
    logic [W-1:0] exp_s = a + b;
    int n = 0;
    bit seen = 0;
    @(negedge clk);
    start_i = 1'b1; a_i = a; b_i = b;
    @(posedge clk);
    #1 start_i = 1'b0;
    for (int k = 1; k <= W + 4; k++) begin
      @(negedge clk);
      if (poke && k == 1 && !done_o) begin
        start_i = 1'b1; a_i = ~a; b_i = 32'h1;
      end else begin
        start_i = 1'b0;
      end
      if (done_o) begin n = k; seen = 1; break; end
    end
    start_i = 1'b0;
    check(seen, {req, " done seen"}, seen, 1);
    if (seen) begin
      check(n == exp_n + 1, {req, " R5 latency"}, n, exp_n + 1);
      check(sum_o == exp_s, {req, " R2 sum"}, sum_o, exp_s);
      check(int'(iters_o) == exp_n, {req, " passes"}, iters_o, exp_n);
      check(iters_o <= W, "R9 count bound", iters_o, W);
      @(negedge clk);
      check(!done_o, {req, " R6 single pulse"}, done_o, 0);
      check(!busy_o, {req, " R6 busy drop"}, busy_o, 0);
      if (poke) check(!busy_o && !done_o, "R7 no extra request", busy_o, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd20240611));
    #20;
    @(negedge clk);
    check(!busy_o && !done_o, "R1 reset state", {busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);

    run_add(32'd2, 32'd6, 0, "R3 two plus six");
    run_add(32'h1234_5678, 32'h0, 0, "R4 zero carry");
    run_add(32'h0, 32'h0, 0, "R4 both zero");
    run_add(32'h0, 32'hDEAD_BEEF, 0, "R2 zero first");
    run_add(32'hFFFF_FFFF, 32'h1, 0, "R8 worst case");
    run_add(32'h8000_0000, 32'h8000_0000, 0, "R2 top carry wrap");
    run_add(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2 all ones");
    run_add(32'h0000_FFFF, 32'h0000_0001, 1, "R7 start while busy");
    run_add(32'hFFFF_FFFF, 32'h0000_0001, 1, "R7 worst case poke");

    for (int i = 0; i < 300; i++) begin
      ra = $urandom();
      rb = $urandom();
      case (i % 4)
        1: rb = rb & 32'h0000_00FF;
        2: ra = ~rb + 32'($urandom_range(0, 3));
        default: ;
      endcase
      run_add(ra, rb, (i % 7) == 0, "R2 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule